// File: doc/BRIEF.md
# Interrupt Controller with Receive Coalescing

This block gathers eight single-cycle event pulses into a sticky flag register. A mask register with the same bit layout selects which flags count as pending. The receive source does not reach its flag directly. Its pulses are counted as received packets, and the receive flag is raised either after a programmable batch of 1, 2, 4 or 8 packets or when a hold-off timer expires on a partial batch. This keeps the interrupt rate low under heavy traffic while still bounding the latency for a lone packet.

A second, summary level sits above the network flags. It holds a network-pending bit and three external event bits: a reset event, a challenge request and a challenge status. A summary mask of its own gates these bits onto the single interrupt line. Software reaches every register through a plain single-cycle register bus. Writes take effect on the clock edge on which `bus_wr` is high. Reads are combinational from `bus_addr`. Flags in both levels clear when 1 is written to them.

Top module: `irq_coalesce_ctrl`

## Requirements
- R1: After reset, all flags, both masks, the summary status and the threshold field read 0x00, the hold-off value reads 0x0600, and `irq_o` is low.
- R2: Source flags sit at address 0 and are sticky. Writing 1 to a bit clears it. An event pulse in the same cycle as a clear of that bit leaves the bit set.
- R3: Flag bit 1 (receive) is set only by the coalescer, never directly by `evt_in[1]`. `evt_in[1]` is the received-packet pulse. Address 2 bits [1:0] choose the batch size: code 00 gives 1 packet, 01 gives 2, 10 gives 4 and 11 gives 8. The flag sets on the edge that captures the last packet of the batch.
- R4: The first packet of a batch starts a hold-off timer whose limit is the 16-bit value at addresses 3 (low byte) and 4 (high byte). When no count threshold is reached first, the receive flag sets on the edge hold+1 cycles after the first-packet edge. Both the packet count and the timer then restart from empty.
- R5: Address 1 is the source mask, where 1 enables a source. Flag bits 0 and 2..7 are fragment counter, transmit, receive error, transmit error, FIFO error, bus error and receive buffer full. The pending set is flags AND mask. A masked flag still reads back set but does not raise the network summary bit.
- R6: Summary bits 6, 4 and 3 at address 5 are set by `ext_evt[2]`, `ext_evt[1]` and `ext_evt[0]`. Each clears when 1 is written to it. Bits 5 and 2..0 always read 0.
- R7: Summary bit 7 sets one cycle after the pending set becomes non-empty. Writing 1 to it has no effect while any pending bit remains.
- R8: The summary mask at address 6 stores only bits 7..3, and other bits read 0. Writing 0x00 blocks every summary bit from the line, and writing 0xF8 enables all of them.
- R9: `irq_o` is high exactly while some summary status bit and its summary mask bit are both 1.
- R10: Address 7 reads 0x00. Writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_in | input | 8 | One-cycle event pulses per source; bit 1 is the received-packet pulse |
| ext_evt | input | 3 | One-cycle pulses for summary bits 3, 4 and 6 |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Combinational register read data |
| irq_o | output | 1 | Interrupt line |

## Verification
Every cycle, the assertions check the following:
- a zeroed summary mask silences the line on the next cycle;
- a pending source forces the network summary bit;
- source flags never drop without a write to address 0;
- the receive flag and summary bit 6 rise only after their own causes;
- the coalescer fires only with a packet or an open batch.

Batch sizes for each threshold code, the exact timer expiry cycle, the restart of count and timer, the same-cycle set-over-clear rule, and the blocked clear of summary bit 7 are sequence properties. Only the bench's scenarios show these, through its cycle-by-cycle reference model and its register readbacks.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int DATA_W  = 8;
  localparam int ADDR_W  = 3;
  localparam int SRC_N   = 8;
  localparam int RX_SRC  = 1;
  localparam int TMR_W   = 16;
  localparam int THR_W   = 2;
  localparam int CNT_W   = (1 << THR_W);
  localparam int EXT_N   = 3;
  localparam int NET_BIT = 7;

  localparam logic [DATA_W-1:0] SUM_PRESENT  = 8'hD8;
  localparam logic [DATA_W-1:0] SUM_MASKABLE = 8'hF8;

  typedef enum logic [ADDR_W-1:0] {
    A_FLAGS    = 3'd0,
    A_MASK     = 3'd1,
    A_CTRL     = 3'd2,
    A_HOLD_LO  = 3'd3,
    A_HOLD_HI  = 3'd4,
    A_SUM      = 3'd5,
    A_SUM_MASK = 3'd6,
    A_RSVD     = 3'd7
  } reg_addr_e;
endpackage

// File: rtl/irqc_rx_coalescer.sv
module irqc_rx_coalescer
  import irqc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pkt_i,
  input  logic [THR_W-1:0] thr_i,
  input  logic [TMR_W-1:0] hold_i,
  output logic             fire_o,
  output logic             active_o
);
  logic [CNT_W-1:0] cnt_q, cnt_inc, target;
  logic [TMR_W-1:0] tmr_q;
  logic             act_q;
  logic             fire_cnt, fire_tmr;

  // batch size is a power of two chosen by the threshold code
  assign target   = CNT_W'(1) << thr_i;
  assign cnt_inc  = cnt_q + 1'b1;
  assign fire_cnt = pkt_i && (cnt_inc >= target);
  assign fire_tmr = act_q && (tmr_q >= hold_i);
  assign fire_o   = fire_cnt | fire_tmr;
  assign active_o = act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      tmr_q <= '0;
      act_q <= 1'b0;
    end else if (fire_o) begin
      cnt_q <= '0;
      tmr_q <= '0;
      act_q <= 1'b0;
    end else begin
      if (pkt_i) cnt_q <= cnt_inc;
      if (act_q) tmr_q <= tmr_q + 1'b1;
      if (pkt_i) act_q <= 1'b1;
    end
  end
endmodule

// File: rtl/irqc_src_bank.sv
module irqc_src_bank
  import irqc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SRC_N-1:0]  set_i,
  input  logic [SRC_N-1:0]  clr_i,
  input  logic              mask_wr_i,
  input  logic [SRC_N-1:0]  mask_d_i,
  output logic [SRC_N-1:0]  flags_o,
  output logic [SRC_N-1:0]  mask_o,
  output logic              pend_any_o
);
  genvar gi;
  generate
    for (gi = 0; gi < SRC_N; gi++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_o[gi] <= 1'b0;
        else        flags_o[gi] <= set_i[gi] | (flags_o[gi] & ~clr_i[gi]);
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         mask_o <= '0;
    else if (mask_wr_i) mask_o <= mask_d_i;
  end

  assign pend_any_o = |(flags_o & mask_o);
endmodule

// File: rtl/irqc_summary.sv
module irqc_summary
  import irqc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              net_pend_i,
  input  logic [EXT_N-1:0]  ext_evt_i,
  input  logic [DATA_W-1:0] clr_i,
  input  logic              mask_wr_i,
  input  logic [DATA_W-1:0] mask_d_i,
  output logic [DATA_W-1:0] status_o,
  output logic [DATA_W-1:0] mask_o,
  output logic              irq_o
);
  logic [DATA_W-1:0] ext_set;
  logic              unused_clr;

  always_comb begin
    ext_set    = '0;
    ext_set[6] = ext_evt_i[2];
    ext_set[4] = ext_evt_i[1];
    ext_set[3] = ext_evt_i[0];
  end

  assign unused_clr = ^(clr_i & ~SUM_PRESENT);

  genvar gi;
  generate
    for (gi = 0; gi < DATA_W; gi++) begin : g_sum
      if (gi == NET_BIT) begin : g_net
        // cannot be cleared while the pending set stays non-empty
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) status_o[gi] <= 1'b0;
          else        status_o[gi] <= net_pend_i | (status_o[gi] & ~clr_i[gi]);
        end
      end else if (SUM_PRESENT[gi]) begin : g_ext
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) status_o[gi] <= 1'b0;
          else        status_o[gi] <= ext_set[gi] | (status_o[gi] & ~clr_i[gi]);
        end
      end else begin : g_none
        assign status_o[gi] = 1'b0;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         mask_o <= '0;
    else if (mask_wr_i) mask_o <= mask_d_i & SUM_MASKABLE;
  end

  assign irq_o = |(status_o & mask_o);
endmodule

// File: rtl/irq_coalesce_ctrl.sv
module irq_coalesce_ctrl
  import irqc_pkg::*;
#(
  parameter logic [TMR_W-1:0] HOLD_RST = 16'h0600
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SRC_N-1:0]  evt_in,
  input  logic [EXT_N-1:0]  ext_evt,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o
);
  logic              wr_flags, wr_mask, wr_ctrl, wr_hlo, wr_hhi, wr_sum, wr_smask;
  logic [THR_W-1:0]  thr_q;
  logic [TMR_W-1:0]  hold_q;
  logic              rx_pkt, rx_fire, rx_active, pend_any;
  logic [SRC_N-1:0]  src_set, src_clr, src_flags, src_mask;
  logic [DATA_W-1:0] sum_clr, sum_status, sum_mask;

  assign wr_flags = bus_wr && (bus_addr == A_FLAGS);
  assign wr_mask  = bus_wr && (bus_addr == A_MASK);
  assign wr_ctrl  = bus_wr && (bus_addr == A_CTRL);
  assign wr_hlo   = bus_wr && (bus_addr == A_HOLD_LO);
  assign wr_hhi   = bus_wr && (bus_addr == A_HOLD_HI);
  assign wr_sum   = bus_wr && (bus_addr == A_SUM);
  assign wr_smask = bus_wr && (bus_addr == A_SUM_MASK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_q  <= '0;
      hold_q <= HOLD_RST;
    end else begin
      if (wr_ctrl) thr_q                <= bus_wdata[THR_W-1:0];
      if (wr_hlo)  hold_q[DATA_W-1:0]   <= bus_wdata;
      if (wr_hhi)  hold_q[TMR_W-1:DATA_W] <= bus_wdata[TMR_W-DATA_W-1:0];
    end
  end

  assign rx_pkt = evt_in[RX_SRC];

  irqc_rx_coalescer u_coal (
    .clk      (clk),
    .rst_n    (rst_n),
    .pkt_i    (rx_pkt),
    .thr_i    (thr_q),
    .hold_i   (hold_q),
    .fire_o   (rx_fire),
    .active_o (rx_active)
  );

  // the receive position takes the coalescer output, the rest pass through
  genvar gi;
  generate
    for (gi = 0; gi < SRC_N; gi++) begin : g_set
      if (gi == RX_SRC) begin : g_rx
        assign src_set[gi] = rx_fire;
      end else begin : g_dir
        assign src_set[gi] = evt_in[gi];
      end
    end
  endgenerate

  assign src_clr = wr_flags ? bus_wdata : '0;
  assign sum_clr = wr_sum   ? bus_wdata : '0;

  irqc_src_bank u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_i      (src_set),
    .clr_i      (src_clr),
    .mask_wr_i  (wr_mask),
    .mask_d_i   (bus_wdata),
    .flags_o    (src_flags),
    .mask_o     (src_mask),
    .pend_any_o (pend_any)
  );

  irqc_summary u_sum (
    .clk        (clk),
    .rst_n      (rst_n),
    .net_pend_i (pend_any),
    .ext_evt_i  (ext_evt),
    .clr_i      (sum_clr),
    .mask_wr_i  (wr_smask),
    .mask_d_i   (bus_wdata),
    .status_o   (sum_status),
    .mask_o     (sum_mask),
    .irq_o      (irq_o)
  );

  always_comb begin
    case (bus_addr)
      A_FLAGS:    bus_rdata = src_flags;
      A_MASK:     bus_rdata = src_mask;
      A_CTRL:     bus_rdata = DATA_W'(thr_q);
      A_HOLD_LO:  bus_rdata = hold_q[DATA_W-1:0];
      A_HOLD_HI:  bus_rdata = hold_q[TMR_W-1:DATA_W];
      A_SUM:      bus_rdata = sum_status;
      A_SUM_MASK: bus_rdata = sum_mask;
      default:    bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker
  import irqc_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              irq_o,
  input logic [SRC_N-1:0]  src_flags,
  input logic              pend_any,
  input logic [DATA_W-1:0] sum_status,
  input logic              rx_fire,
  input logic              rx_pkt,
  input logic              rx_active,
  input logic [EXT_N-1:0]  ext_evt
);
  assert_mask_zero_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 3'd6 && bus_wdata == 8'h00) |=> !irq_o);

  assert_net_bit_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pend_any |=> sum_status[NET_BIT]);

  assert_flags_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == 3'd0) |=> ((src_flags & $past(src_flags)) == $past(src_flags)));

  assert_rx_from_coalescer_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(src_flags[RX_SRC]) |-> $past(rx_fire));

  assert_fire_has_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_fire |-> (rx_pkt || rx_active));

  assert_reset_evt_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sum_status[6]) |-> $past(ext_evt[2]));
endmodule

bind irq_coalesce_ctrl irqc_checker u_irqc_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .irq_o      (irq_o),
  .src_flags  (src_flags),
  .pend_any   (pend_any),
  .sum_status (sum_status),
  .rx_fire    (rx_fire),
  .rx_pkt     (rx_pkt),
  .rx_active  (rx_active),
  .ext_evt    (ext_evt)
);

// File: tb/test_irq_coalesce_ctrl.sv
module test_irq_coalesce_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] evt_in = '0;
  logic [2:0] ext_evt = '0;
  logic       bus_wr = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       irq_o;

  int checks = 0;
  int errors = 0;
  bit run_chk = 0;
  bit done = 0;

  always #4 clk = ~clk;

  irq_coalesce_ctrl i_irq_coalesce_ctrl (
    .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .ext_evt(ext_evt),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  // behavioural reference model
  logic [7:0]  m_ir, m_imr, m_st, m_sm, m_set, m_pend, m_clr;
  logic [1:0]  m_thr;
  logic [15:0] m_hold;
  int          m_cnt, m_tmr, m_need;
  bit          m_act, m_fire, m_pkt;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ir = 0; m_imr = 0; m_st = 0; m_sm = 0; m_thr = 0; m_hold = 16'h0600;
      m_cnt = 0; m_tmr = 0; m_act = 0;
    end else begin
      m_need = 1 << m_thr;
      m_pkt  = evt_in[1];
      m_fire = (m_pkt && (m_cnt + 1 >= m_need)) || (m_act && (m_tmr >= m_hold));
      m_pend = m_ir & m_imr;
      m_set  = evt_in;
      m_set[1] = m_fire;
      m_clr  = (bus_wr && bus_addr == 0) ? bus_wdata : 8'h00;
      m_ir   = m_set | (m_ir & ~m_clr);
      m_clr  = (bus_wr && bus_addr == 5) ? bus_wdata : 8'h00;
      m_st[7] = (m_pend != 0) | (m_st[7] & ~m_clr[7]);
      m_st[6] = ext_evt[2] | (m_st[6] & ~m_clr[6]);
      m_st[4] = ext_evt[1] | (m_st[4] & ~m_clr[4]);
      m_st[3] = ext_evt[0] | (m_st[3] & ~m_clr[3]);
      if (m_fire) begin
        m_cnt = 0; m_tmr = 0; m_act = 0;
      end else begin
        if (m_pkt) m_cnt = m_cnt + 1;
        if (m_act) m_tmr = m_tmr + 1;
        if (m_pkt) m_act = 1;
      end
      if (bus_wr) begin
        case (bus_addr)
          3'd1: m_imr = bus_wdata;
          3'd2: m_thr = bus_wdata[1:0];
          3'd3: m_hold[7:0] = bus_wdata;
          3'd4: m_hold[15:8] = bus_wdata;
          3'd6: m_sm = bus_wdata & 8'hF8;
          default: ;
        endcase
      end
    end
  end

  function automatic logic [7:0] m_read(input logic [2:0] a);
    case (a)
      3'd0: return m_ir;
      3'd1: return m_imr;
      3'd2: return {6'b0, m_thr};
      3'd3: return m_hold[7:0];
      3'd4: return m_hold[15:8];
      3'd5: return m_st;
      3'd6: return m_sm;
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // line compared with the model on every cycle (R9)
  always @(negedge clk) begin
    if (run_chk) check(irq_o === |(m_st & m_sm), "R9 irq line", irq_o, |(m_st & m_sm));
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic pulse(input logic [7:0] v);
    @(negedge clk); evt_in = v;
    @(negedge clk); evt_in = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd_exp(input logic [2:0] a, input logic [7:0] e, input string tag);
    @(negedge clk); bus_addr = a; #1;
    check(bus_rdata === e, tag, bus_rdata, e);
    check(bus_rdata === m_read(a), {tag, " model"}, bus_rdata, m_read(a));
  endtask

  task automatic packets(input int n);
    for (int k = 0; k < n; k++) pulse(8'h02);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    run_chk = 1;
    // R1 reset state
    rd_exp(0, 8'h00, "R1 flags");
    rd_exp(1, 8'h00, "R1 mask");
    rd_exp(2, 8'h00, "R1 ctrl");
    rd_exp(3, 8'h00, "R1 hold lo");
    rd_exp(4, 8'h06, "R1 hold hi");
    rd_exp(5, 8'h00, "R1 summary");
    rd_exp(6, 8'h00, "R1 summary mask");
    check(irq_o === 1'b0, "R1 irq", irq_o, 0);

    wr(1, 8'hFF);
    wr(6, 8'hF8);
    rd_exp(6, 8'hF8, "R8 mask all");
    // transmit event -> pending -> summary bit 7
    pulse(8'h04); idle(2);
    rd_exp(0, 8'h04, "R5 transmit flag");
    rd_exp(5, 8'h80, "R7 net bit");
    check(irq_o === 1'b1, "R9 irq high", irq_o, 1);
    wr(5, 8'h80); idle(1);
    rd_exp(5, 8'h80, "R7 clear blocked");
    wr(0, 8'h04); wr(5, 8'h80); idle(1);
    rd_exp(5, 8'h00, "R7 cleared");
    rd_exp(0, 8'h00, "R2 w1c");

    // masked source
    wr(1, 8'hFB);
    pulse(8'h04); idle(3);
    rd_exp(0, 8'h04, "R5 masked flag kept");
    rd_exp(5, 8'h00, "R5 masked no net");
    wr(0, 8'hFF); wr(1, 8'hFF);

    // set wins over same-cycle clear
    @(negedge clk); bus_wr = 1; bus_addr = 0; bus_wdata = 8'h01; evt_in = 8'h01;
    @(negedge clk); bus_wr = 0; evt_in = 0;
    rd_exp(0, 8'h01, "R2 set wins");
    wr(0, 8'h01); idle(1); wr(5, 8'h80);

    // R10 reserved address
    wr(7, 8'hFF);
    rd_exp(7, 8'h00, "R10 reserved read");
    rd_exp(1, 8'hFF, "R10 mask untouched");

    // R3 thresholds
    pulse(8'h02);
    rd_exp(0, 8'h02, "R3 code00 one packet");
    wr(0, 8'h02); idle(1); wr(5, 8'h80);
    wr(2, 8'h01);
    packets(1); rd_exp(0, 8'h00, "R3 code01 after 1");
    packets(1); rd_exp(0, 8'h02, "R3 code01 after 2");
    wr(0, 8'h02); idle(1); wr(5, 8'h80);
    wr(2, 8'h02);
    packets(3); rd_exp(0, 8'h00, "R3 code10 after 3");
    packets(1); rd_exp(0, 8'h02, "R3 code10 after 4");
    wr(0, 8'h02); idle(1); wr(5, 8'h80);
    wr(2, 8'h03);
    packets(7); rd_exp(0, 8'h00, "R3 code11 after 7");
    packets(1); rd_exp(0, 8'h02, "R3 code11 after 8");
    wr(0, 8'h02); idle(1); wr(5, 8'h80);

    // R4 hold-off timer on a partial batch
    wr(3, 8'h05); wr(4, 8'h00);
    packets(2);
    rd_exp(0, 8'h00, "R4 before expiry");
    idle(8);
    rd_exp(0, 8'h02, "R4 expiry");
    wr(0, 8'h02); idle(1); wr(5, 8'h80);
    // restart: a fresh batch times out again
    wr(3, 8'h14);
    packets(3); idle(4);
    rd_exp(0, 8'h00, "R4 restart count");
    idle(25);
    rd_exp(0, 8'h02, "R4 second expiry");
    wr(0, 8'h02); idle(1); wr(5, 8'h80);

    // R6 summary events, R8 mask gating
    wr(1, 8'h00);
    @(negedge clk); ext_evt = 3'b111;
    @(negedge clk); ext_evt = 0;
    rd_exp(5, 8'h58, "R6 ext bits");
    check(irq_o === 1'b1, "R9 ext irq", irq_o, 1);
    wr(6, 8'h00); idle(1);
    check(irq_o === 1'b0, "R8 all blocked", irq_o, 0);
    wr(5, 8'h10);
    rd_exp(5, 8'h48, "R6 clear bit4");
    wr(6, 8'hFF);
    rd_exp(6, 8'hF8, "R8 stored bits");
    wr(5, 8'h48);
    rd_exp(5, 8'h00, "R6 all cleared");
    idle(2);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R9 watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule